// File: doc/BRIEF.md
# DMA Channel Start and Interrupt Control

This block is the register and control front end of a seven-channel DMA engine. Software writes, for each channel, a transfer address, a block count and a control word. It also writes a shared channel-enable register and a shared interrupt register. The block decides when a channel may launch a transfer, and it tells the data mover with a one-cycle start strobe. It records completion reports from the channels as interrupt flags. It sends a single interrupt-request pulse to the system interrupt controller each time the combined interrupt condition goes from false to true.

The register port is a simple single-cycle bus. A write is taken on the clock edge where `reg_we` is high, and `reg_rdata` returns the register selected by `reg_addr` with no wait. Completion reports and bus-error reports are one-cycle pulses. Moving the data, arbitrating between channels and driving memory all sit outside this block.

Top module: `dmac_start_irq`

## Requirements
- R1: Channel n (0..6) keeps its address word at offset 0x80+0x10·n, its block count at +0x4 and its control word at +0x8. The channel-enable word sits at 0xF0 and the interrupt word at 0xF4. Address, count and enable words read back exactly as written. An offset that maps to no register reads as zero.
- R2: After reset every register reads zero, and `ch_start` and `irq_pulse` are low.
- R3: A write to channel n's control word stores the value. `ch_start[n]` is high for exactly the one cycle after the write edge, and only when bit 24 of the written value is 1 and bit 3+4·n of the enable word is 1. In every other case no start strobe appears.
- R4: A `ch_done[n]` pulse clears bit 24 of channel n's control word and leaves the other bits as they are. A write to that same control word in the same cycle takes precedence.
- R5: A write to the interrupt word loads bits 5:0, bit 15, bits 22:16 and bit 23 (mask 0x00FF803F) from the written value. Bits 14:6 always read zero.
- R6: Flag bits 30:24 of the interrupt word are cleared where the written value has a 1 and kept where it has a 0.
- R7: A `ch_done[n]` pulse sets flag bit 24+n when enable bit 16+n of the interrupt word is 1, and has no effect on the flag otherwise. A flag that is set and cleared in the same cycle ends up set.
- R8: A `bus_err` pulse sets bit 15 of the interrupt word. This takes precedence over a write that clears bit 15 in the same cycle.
- R9: After every update, bit 31 of the interrupt word is 1 exactly when bit 15 is 1, or when bit 23 is 1 and at least one flag in bits 30:24 is 1.
- R10: `irq_pulse` is high for one cycle after the edge on which bit 31 changes from 0 to 1. It stays low while bit 31 stays at 1, whatever else happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register being read or written |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` |
| ch_done | input | 7 | Per-channel completion pulse |
| bus_err | input | 1 | Bus-error report pulse |
| ch_start | output | 7 | Per-channel start strobe, one cycle |
| irq_pulse | output | 1 | Interrupt request pulse to the system interrupt controller |

## Verification
Start launches are tried with the enable bit clear and then set, on more than one channel, and with bit 24 low. This separates the enable-bit gate from the start-bit gate, and it shows that the per-channel bit position is decoded correctly. The interrupt word is driven three ways: by completion reports with the per-channel enable set and cleared, by bus errors, and by writes of all ones and all zeros. The same stimulus runs both with the master flag already high and from a clear state, so that a real 0-to-1 edge can be told apart from repeated setting. Set and clear arriving in the same cycle are covered, both for flags and for the start bit. A long random phase then mixes writes, completions and errors, and every clock is compared against a behavioural model.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int GO_BIT     = 24;  // start request in a channel control word
   localparam int EN_FIRST   = 3;   // enable bit of channel 0 in the enable word
   localparam int EN_STEP    = 4;   // spacing of enable bits between channels
   localparam int MISC_W     = 6;   // plain writable low bits of the interrupt word
   localparam int BERR_BIT   = 15;
   localparam int DEN_LO     = 16;  // per-channel completion enables
   localparam int GEN_BIT    = 23;
   localparam int FLAG_LO    = 24;  // per-channel completion flags
   localparam int MASTER_BIT = 31;
   localparam int MAX_CH     = 7;

   function automatic logic [31:0] irq_write_mask(input int nch);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < MISC_W; i++) m[i] = 1'b1;
      m[BERR_BIT] = 1'b1;
      for (int i = 0; i < nch; i++) m[DEN_LO + i] = 1'b1;
      m[GEN_BIT] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] irq_flag_mask(input int nch);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < nch; i++) m[FLAG_LO + i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
   import dmac_pkg::*;
#(
   parameter int NCH       = 7,
   parameter int DW        = 32,
   parameter int AW        = 8,
   parameter int CH_BASE   = 'h80,
   parameter int CH_STRIDE = 'h10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [NCH-1:0] en_go,
   input  logic [NCH-1:0] ch_done,
   output logic [DW-1:0] addr_q [NCH],
   output logic [DW-1:0] cnt_q  [NCH],
   output logic [DW-1:0] ctl_q  [NCH],
   output logic [NCH-1:0] ch_start
);
   localparam int OFS_CNT = 4;
   localparam int OFS_CTL = 8;

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam logic [AW-1:0] A_ADR = AW'(CH_BASE + n * CH_STRIDE);
      localparam logic [AW-1:0] A_CNT = AW'(CH_BASE + n * CH_STRIDE + OFS_CNT);
      localparam logic [AW-1:0] A_CTL = AW'(CH_BASE + n * CH_STRIDE + OFS_CTL);

      logic hit_adr, hit_cnt, hit_ctl;
      assign hit_adr = we && (addr == A_ADR);
      assign hit_cnt = we && (addr == A_CNT);
      assign hit_ctl = we && (addr == A_CTL);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q[n]   <= '0;
            cnt_q[n]    <= '0;
            ctl_q[n]    <= '0;
            ch_start[n] <= 1'b0;
         end else begin
            if (hit_adr) addr_q[n] <= wdata;
            if (hit_cnt) cnt_q[n]  <= wdata;
            if (hit_ctl)
               ctl_q[n] <= wdata;
            else if (ch_done[n])
               ctl_q[n][GO_BIT] <= 1'b0;
            ch_start[n] <= hit_ctl && wdata[GO_BIT] && en_go[n];
         end
      end
   end
endmodule

// File: rtl/dmac_irq_unit.sv
module dmac_irq_unit
   import dmac_pkg::*;
#(
   parameter int NCH = 7,
   parameter int DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we_irq,
   input  logic [DW-1:0]  wdata,
   input  logic [NCH-1:0] ch_done,
   input  logic           bus_err,
   output logic [DW-1:0]  irq_q,
   output logic           irq_pulse
);
   localparam logic [31:0] WMASK = irq_write_mask(NCH);
   localparam logic [31:0] FMASK = irq_flag_mask(NCH);

   logic [DW-1:0] staged;
   logic          cond;

   always_comb begin
      staged = irq_q;
      staged[MASTER_BIT] = 1'b0;
      if (we_irq)
         staged = (wdata & WMASK) | (irq_q & ~wdata & FMASK);
      for (int n = 0; n < NCH; n++)
         if (ch_done[n] && staged[DEN_LO + n])
            staged[FLAG_LO + n] = 1'b1;
      if (bus_err)
         staged[BERR_BIT] = 1'b1;
      cond = staged[BERR_BIT] | (staged[GEN_BIT] & (|(staged & FMASK)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q     <= '0;
         irq_pulse <= 1'b0;
      end else begin
         irq_q             <= staged;
         irq_q[MASTER_BIT] <= cond;
         irq_pulse         <= cond & ~irq_q[MASTER_BIT];
      end
   end
endmodule

// File: rtl/dmac_read_mux.sv
module dmac_read_mux #(
   parameter int NCH       = 7,
   parameter int DW        = 32,
   parameter int AW        = 8,
   parameter int CH_BASE   = 'h80,
   parameter int CH_STRIDE = 'h10,
   parameter int EN_ADDR   = 'hF0,
   parameter int IRQ_ADDR  = 'hF4
) (
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] addr_q [NCH],
   input  logic [DW-1:0] cnt_q  [NCH],
   input  logic [DW-1:0] ctl_q  [NCH],
   input  logic [DW-1:0] en_q,
   input  logic [DW-1:0] irq_q,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] part [NCH+1];

   assign part[0] = ((addr == AW'(EN_ADDR))  ? en_q  : '0)
                  | ((addr == AW'(IRQ_ADDR)) ? irq_q : '0);

   for (genvar n = 0; n < NCH; n++) begin : g_rd
      localparam logic [AW-1:0] A_ADR = AW'(CH_BASE + n * CH_STRIDE);
      localparam logic [AW-1:0] A_CNT = AW'(CH_BASE + n * CH_STRIDE + 4);
      localparam logic [AW-1:0] A_CTL = AW'(CH_BASE + n * CH_STRIDE + 8);
      assign part[n+1] = part[n]
                       | ((addr == A_ADR) ? addr_q[n] : '0)
                       | ((addr == A_CNT) ? cnt_q[n]  : '0)
                       | ((addr == A_CTL) ? ctl_q[n]  : '0);
   end

   assign rdata = part[NCH];
endmodule

// File: rtl/dmac_start_irq.sv
module dmac_start_irq
   import dmac_pkg::*;
#(
   parameter int NCH       = 7,
   parameter int DW        = 32,
   parameter int AW        = 8,
   parameter int CH_BASE   = 'h80,
   parameter int CH_STRIDE = 'h10,
   parameter int EN_ADDR   = 'hF0,
   parameter int IRQ_ADDR  = 'hF4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_we,
   input  logic [AW-1:0]  reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata,
   input  logic [NCH-1:0] ch_done,
   input  logic           bus_err,
   output logic [NCH-1:0] ch_start,
   output logic           irq_pulse
);
   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("dmac_start_irq: NCH must be 1..7");
   end
   if (DW != 32) begin : g_bad_dw
      $error("dmac_start_irq: DW must be 32");
   end
   if (CH_BASE + NCH * CH_STRIDE > EN_ADDR || CH_STRIDE < 12) begin : g_bad_map
      $error("dmac_start_irq: channel window overlaps shared registers");
   end
   if (IRQ_ADDR >= (1 << AW) || EN_ADDR == IRQ_ADDR) begin : g_bad_addr
      $error("dmac_start_irq: shared register offsets invalid");
   end

   logic [DW-1:0]  addr_q [NCH];
   logic [DW-1:0]  cnt_q  [NCH];
   logic [DW-1:0]  ctl_q  [NCH];
   logic [DW-1:0]  en_q;
   logic [DW-1:0]  irq_q;
   logic [NCH-1:0] en_go;
   logic [NCH-1:0] go_vec;

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= '0;
      else if (reg_we && reg_addr == AW'(EN_ADDR))
         en_q <= reg_wdata;
   end

   for (genvar n = 0; n < NCH; n++) begin : g_map
      assign en_go[n]  = en_q[EN_FIRST + EN_STEP * n];
      assign go_vec[n] = ctl_q[n][GO_BIT];
   end

   dmac_chan_regs #(
      .NCH(NCH), .DW(DW), .AW(AW), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
   ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .en_go    (en_go),
      .ch_done  (ch_done),
      .addr_q   (addr_q),
      .cnt_q    (cnt_q),
      .ctl_q    (ctl_q),
      .ch_start (ch_start)
   );

   dmac_irq_unit #(.NCH(NCH), .DW(DW)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_irq    (reg_we && reg_addr == AW'(IRQ_ADDR)),
      .wdata     (reg_wdata),
      .ch_done   (ch_done),
      .bus_err   (bus_err),
      .irq_q     (irq_q),
      .irq_pulse (irq_pulse)
   );

   dmac_read_mux #(
      .NCH(NCH), .DW(DW), .AW(AW), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE),
      .EN_ADDR(EN_ADDR), .IRQ_ADDR(IRQ_ADDR)
   ) u_rd (
      .addr   (reg_addr),
      .addr_q (addr_q),
      .cnt_q  (cnt_q),
      .ctl_q  (ctl_q),
      .en_q   (en_q),
      .irq_q  (irq_q),
      .rdata  (reg_rdata)
   );
endmodule

// File: rtl/dmac_start_irq_chk.sv
module dmac_start_irq_chk #(
   parameter int NCH       = 7,
   parameter int AW        = 8,
   parameter int CH_BASE   = 'h80,
   parameter int CH_STRIDE = 'h10
) (
   input logic           clk,
   input logic           rst_n,
   input logic           reg_we,
   input logic [AW-1:0]  reg_addr,
   input logic           wr_go,
   input logic [NCH-1:0] ch_done,
   input logic           bus_err,
   input logic [NCH-1:0] ch_start,
   input logic           irq_pulse,
   input logic [NCH-1:0] en_go,
   input logic [NCH-1:0] go_vec,
   input logic           mflag,
   input logic           berr,
   input logic           gen,
   input logic [NCH-1:0] flags,
   input logic [8:0]     dead_bits
);
   p_dead_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dead_bits == 9'd0);

   p_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mflag == (berr | (gen & (|flags))));

   p_pulse_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (mflag && !$past(mflag)));

   p_rise_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mflag) |-> irq_pulse);

   p_berr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> berr);

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam logic [AW-1:0] A_CTL = AW'(CH_BASE + n * CH_STRIDE + 8);

      p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ch_start[n] |-> $past(reg_we && reg_addr == A_CTL && wr_go && en_go[n]));

      p_start_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ch_start[n] |=> !ch_start[n] || $past(reg_we && reg_addr == A_CTL));

      p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_done[n] && !(reg_we && reg_addr == A_CTL)) |=> !go_vec[n]);
   end
endmodule

bind dmac_start_irq dmac_start_irq_chk #(
   .NCH(NCH), .AW(AW), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .wr_go     (reg_wdata[24]),
   .ch_done   (ch_done),
   .bus_err   (bus_err),
   .ch_start  (ch_start),
   .irq_pulse (irq_pulse),
   .en_go     (en_go),
   .go_vec    (go_vec),
   .mflag     (irq_q[31]),
   .berr      (irq_q[15]),
   .gen       (irq_q[23]),
   .flags     (irq_q[24 +: NCH]),
   .dead_bits (irq_q[14:6])
);

// File: tb/tb_dmac_start_irq.sv
module tb_dmac_start_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [6:0]  ch_done = '0;
   logic        bus_err = 1'b0;
   logic [6:0]  ch_start;
   logic        irq_pulse;

   always #5 clk = ~clk;

   dmac_start_irq dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_done(ch_done),
      .bus_err(bus_err), .ch_start(ch_start), .irq_pulse(irq_pulse)
   );

   int n_cmp = 0;
   int n_bad = 0;
   string tag = "R2";

   // behavioural reference
   logic [31:0] m_adr [7];
   logic [31:0] m_cnt [7];
   logic [31:0] m_ctl [7];
   logic [31:0] m_en, m_irq;
   logic [6:0]  m_start;
   logic        m_pulse;

   function automatic logic [31:0] m_read(input logic [7:0] a);
      if (a == 8'hF0) return m_en;
      if (a == 8'hF4) return m_irq;
      for (int n = 0; n < 7; n++) begin
         if (a == 8'h80 + 8'(16 * n)) return m_adr[n];
         if (a == 8'h84 + 8'(16 * n)) return m_cnt[n];
         if (a == 8'h88 + 8'(16 * n)) return m_ctl[n];
      end
      return 32'h0;
   endfunction

   task automatic model_step();
      logic [31:0] t;
      logic        c;
      if (!rst_n) begin
         for (int n = 0; n < 7; n++) begin
            m_adr[n] = '0; m_cnt[n] = '0; m_ctl[n] = '0;
         end
         m_en = '0; m_irq = '0; m_start = '0; m_pulse = 1'b0;
         return;
      end
      m_start = '0;
      for (int n = 0; n < 7; n++) begin
         if (reg_we && reg_addr == 8'h80 + 8'(16 * n)) m_adr[n] = reg_wdata;
         if (reg_we && reg_addr == 8'h84 + 8'(16 * n)) m_cnt[n] = reg_wdata;
         if (reg_we && reg_addr == 8'h88 + 8'(16 * n)) begin
            m_ctl[n]   = reg_wdata;
            m_start[n] = reg_wdata[24] && m_en[3 + 4 * n];
         end else if (ch_done[n]) begin
            m_ctl[n][24] = 1'b0;
         end
      end
      t = {1'b0, m_irq[30:0]};
      if (reg_we && reg_addr == 8'hF4)
         t = (reg_wdata & 32'h00FF803F) | (m_irq & ~reg_wdata & 32'h7F000000);
      for (int n = 0; n < 7; n++)
         if (ch_done[n] && t[16 + n]) t[24 + n] = 1'b1;
      if (bus_err) t[15] = 1'b1;
      c = t[15] || (t[23] && t[30:24] != 7'd0);
      m_pulse = c && !m_irq[31];
      t[31] = c;
      if (reg_we && reg_addr == 8'hF0) m_en = reg_wdata;
      m_irq = t;
   endtask

   task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare after posedge
   task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [6:0] dn, input logic er);
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = d; ch_done = dn; bus_err = er;
      @(posedge clk);
      model_step();
      #2;
      cmp("rdata", reg_rdata, m_read(a));
      cmp("ch_start", {25'd0, ch_start}, {25'd0, m_start});
      cmp("irq_pulse", {31'd0, irq_pulse}, {31'd0, m_pulse});
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 7'd0, 1'b0);
   endtask
   task automatic rd(input logic [7:0] a);
      cyc(1'b0, a, 32'h0, 7'd0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      // R2: reset state
      tag = "R2";
      cyc(1'b0, 8'h80, 32'h0, 7'd0, 1'b0);
      cyc(1'b0, 8'h80, 32'h0, 7'd0, 1'b0);
      rst_n = 1'b1;
      rd(8'hF4); cmp("irq word after reset", reg_rdata, 32'h0);
      rd(8'hF0); rd(8'h88); rd(8'hE8);

      // R1: map and storage
      tag = "R1";
      wr(8'h80, 32'hDEADBEEF); wr(8'h84, 32'h00010020);
      wr(8'hE0, 32'h12345678); wr(8'hE4, 32'hA5A5A5A5);
      rd(8'h80); cmp("ch0 address", reg_rdata, 32'hDEADBEEF);
      rd(8'hE4); cmp("ch6 count", reg_rdata, 32'hA5A5A5A5);
      rd(8'h8C); cmp("unmapped 0x8C", reg_rdata, 32'h0);
      rd(8'hFC); cmp("unmapped 0xFC", reg_rdata, 32'h0);

      // R3: start gating by enable bit 3+4n
      tag = "R3";
      wr(8'hA8, 32'h01000201);
      cmp("ch2 start without enable", {25'd0, ch_start}, 32'h0);
      wr(8'hF0, 32'h00000800);
      wr(8'hA8, 32'h01000201);
      cmp("ch2 start with enable", {25'd0, ch_start}, 32'h4);
      rd(8'hA8);
      cmp("ch2 start lasts one cycle", {25'd0, ch_start}, 32'h0);
      wr(8'hE8, 32'h01000000);
      cmp("ch6 start, wrong enable bit", {25'd0, ch_start}, 32'h0);
      wr(8'hF0, 32'h08000000);
      wr(8'hE8, 32'h00000001);
      cmp("ch6 start with bit24 low", {25'd0, ch_start}, 32'h0);

      // R4: done clears start bit
      tag = "R4";
      cyc(1'b0, 8'hA8, 32'h0, 7'b0000100, 1'b0);
      cmp("ch2 control after done", reg_rdata, 32'h00000201);
      cyc(1'b1, 8'hA8, 32'h01000003, 7'b0000100, 1'b0);
      cmp("write wins over done", reg_rdata, 32'h01000003);

      // R7 / R10: completion flags and edge pulse
      tag = "R7";
      wr(8'hF4, 32'h00840000);
      cmp("irq word enables only", reg_rdata, 32'h00840000);
      cyc(1'b0, 8'hF4, 32'h0, 7'b0000100, 1'b0);
      cmp("flag 26 set, master set", reg_rdata, 32'h84840000);
      cmp("pulse on rise", {31'd0, irq_pulse}, 32'h1);
      tag = "R10";
      cyc(1'b0, 8'hF4, 32'h0, 7'b0000100, 1'b0);
      cmp("no pulse while master held", {31'd0, irq_pulse}, 32'h0);
      tag = "R7";
      cyc(1'b0, 8'hF4, 32'h0, 7'b0001000, 1'b0);
      cmp("disabled channel sets no flag", reg_rdata, 32'h84840000);

      // R6: write-one-to-clear
      tag = "R6";
      wr(8'hF4, 32'h00840000);
      cmp("zero keeps flag", reg_rdata, 32'h84840000);
      wr(8'hF4, 32'h04840000);
      cmp("one clears flag, master drops", reg_rdata, 32'h00840000);
      tag = "R7";
      cyc(1'b1, 8'hF4, 32'h04840000, 7'b0000100, 1'b0);
      cmp("set wins over clear", reg_rdata, 32'h84840000);
      wr(8'hF4, 32'h7F000000);

      // R8: bus error
      tag = "R8";
      cyc(1'b0, 8'hF4, 32'h0, 7'd0, 1'b1);
      cmp("bus error sets bit15", reg_rdata, 32'h80008000);
      cmp("bus error pulse", {31'd0, irq_pulse}, 32'h1);
      cyc(1'b1, 8'hF4, 32'h0, 7'd0, 1'b1);
      cmp("bus error beats clear", reg_rdata, 32'h80008000);
      wr(8'hF4, 32'h0);
      cmp("bit15 writable to zero", reg_rdata, 32'h0);

      // R5: write mask
      tag = "R5";
      wr(8'hF4, 32'hFFFFFFFF);
      cmp("all-ones write", reg_rdata, 32'h80FF803F);
      cmp("pulse from written bit15", {31'd0, irq_pulse}, 32'h1);
      wr(8'hF4, 32'h00000000);

      // R9: mixed random traffic, compared every clock
      tag = "R9";
      for (int i = 0; i < 3000; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         int          k;
         k = int'($urandom_range(0, 9));
         if (k < 7) a = 8'h88 + 8'(16 * k);
         else if (k == 7) a = 8'hF0;
         else a = 8'hF4;
         d = $urandom;
         if (a == 8'hF4 && $urandom_range(0, 1) == 1) d[15] = 1'b0;
         cyc($urandom_range(0, 2) == 0, a, d,
             7'($urandom) & 7'($urandom) & 7'($urandom),
             $urandom_range(0, 15) == 0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule